// File: doc/BRIEF.md
# CAN Receive Frame Memory Writer

This block copies one accepted CAN frame from a 13-byte receive staging buffer into the message buffer that belongs to the receiving message object. The buffer sits in system memory. The block reaches memory as a bus master that asks for the bus before each word and writes only when the bus is granted.

The target address is 24 bits wide. Its upper byte comes from a segment value that all objects share, and its lower 16 bits come from the object's own base value. A 3-bit code sets the buffer size. The base must be aligned to that size; if it is not, the request is refused with an error pulse.

Only the frame-info byte and the data bytes are stored. The stored byte count is clipped to the buffer size, and an overflow indication is raised when it is clipped. For objects that are not in fragmented mode, the received identifier is returned for the object's ID registers when the transfer completes. It is merged through the acceptance mask, so that only don't-care bits can change.

Top module: `can_rx_dma_assembler`

## Requirements
- R1: Word k of a transfer is written at address {segment_i, obj_base_i + 2k}, where segment_i gives address bits 23:16 and the sum gives bits 15:0.
- R2: The buffer size is 2 << obj_size_i bytes, so codes 0 to 7 give 2 to 256 bytes. The number of bytes stored is min(1 + DLC, buffer size), and the block writes ceil(stored/2) words.
- R3: Memory image byte 0 is the frame-info byte and image byte j (1..8) is data byte j. Word k carries image byte 2k on bus_wdata_o[7:0] with bus_be_o[0], and image byte 2k+1 on [15:8] with bus_be_o[1]. A trailing single byte is written with bus_be_o = 01 and the upper lane zero. Write addresses are always even.
- R4: A start with obj_base_i not aligned to the buffer size (any of base bits log2(size)-1..0 set) produces a one-cycle cfg_err_o pulse in the following cycle. It causes no bus request and no done pulse.
- R5: Each word has its own request. While bus_req_o is high and not granted, the address, data and strobes stay unchanged. In the cycle after a grant, bus_req_o is low. A write takes place in a cycle where bus_req_o and bus_gnt_i are both high.
- R6: overflow_o is high together with done_o when 1 + DLC exceeds the buffer size, and low with done_o otherwise.
- R7: done_o is a single-cycle pulse in the cycle after the last word is granted. done_idx_o then carries the object index that was captured at start.
- R8: bus_onchip_o is high during a request exactly when obj_base_i[15:9] equals ram_page_i.
- R9: When obj_frag_i is 0, id_we_o pulses together with done_o. id_wdata_o equals obj_id_i with only the bits set in obj_mask_i (1 = don't care) taken from the received identifier. When obj_frag_i is 1, id_we_o stays low.
- R10: A start pulse while a transfer is in progress is ignored. The running transfer and its done index are unaffected, and no further transfer follows.
- R11: The DLC is frame-info bits 3:0, and a DLC above 8 counts as 8.
- R12: The staging buffer holds the frame-info byte in byte 0 (bit 7 = extended frame), the identifier in bytes 1 to 4 (bits 28:0 of {byte4, byte3, byte2, byte1}; bits 31:29 ignored), and data bytes 1 to 8 in bytes 5 to 12. Byte i of the staging buffer is prebuf_i[8i+7:8i]. For a standard frame, only identifier bits 10:0 are merged and bits 28:11 of the stored identifier are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one frame transfer |
| obj_idx_i | input | 4 | Receiving message object index |
| prebuf_i | input | 104 | Receive staging buffer contents, 13 bytes |
| segment_i | input | 8 | Shared address bits 23:16 |
| obj_base_i | input | 16 | Object buffer base, address bits 15:0 |
| obj_size_i | input | 3 | Object buffer size code |
| obj_frag_i | input | 1 | Object is in fragmented mode |
| obj_id_i | input | 29 | Object's stored identifier |
| obj_mask_i | input | 29 | Object's acceptance mask, 1 = don't care |
| ram_page_i | input | 7 | On-chip RAM window, address bits 15:9 |
| bus_gnt_i | input | 1 | Bus grant |
| bus_req_o | output | 1 | Bus request; write qualifier |
| bus_addr_o | output | 24 | Write address |
| bus_wdata_o | output | 16 | Write data |
| bus_be_o | output | 2 | Byte lane strobes |
| bus_onchip_o | output | 1 | Write target lies in on-chip RAM |
| done_o | output | 1 | Transfer complete pulse |
| done_idx_o | output | 4 | Object index of the completed transfer |
| overflow_o | output | 1 | Frame was clipped to the buffer size |
| cfg_err_o | output | 1 | Misaligned base; start refused |
| id_we_o | output | 1 | Identifier write-back strobe |
| id_wdata_o | output | 29 | Merged identifier to store |

## Verification
Two events can coincide: a fresh start pulse and a transfer that is still in progress, often one stalled while it waits for a grant. The bench provokes this by pulsing start with a different object index partway through a frame, while it withholds grants for a varying number of cycles. The collision is judged at the ports. The done index must still be the original one, the number of granted words must match the first frame's byte count, and no new request may appear after done. The cycle of the done pulse is also checked. It carries the overflow flag and the identifier write-back, so those must come out in that same cycle and nowhere else.

// File: rtl/can_rxdma_pkg.sv
package can_rxdma_pkg;
  localparam int ID_W           = 29;
  localparam int STD_ID_W       = 11;
  localparam int ID_FIELD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } rxdma_state_e;

  // Buffer capacity in bytes for a 3-bit size code.
  function automatic logic [8:0] buf_bytes(input logic [2:0] code);
    return 9'd2 << code;
  endfunction
endpackage

// File: rtl/rxdma_rst_sync.sv
module rxdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxdma_cfg_check.sv
module rxdma_cfg_check
  import can_rxdma_pkg::*;
#(
  parameter int DATA_MAX = 8,
  parameter int CNT_W    = 4
) (
  input  logic [15:0]      base_i,
  input  logic [2:0]       size_code_i,
  input  logic [6:0]       ram_page_i,
  input  logic [3:0]       dlc_i,
  output logic             aligned_o,
  output logic             onchip_o,
  output logic             overflow_o,
  output logic [CNT_W-1:0] nbytes_o
);
  logic [8:0] size_b;
  int         dlc_clip;
  int         frame_bytes;

  always_comb begin
    size_b      = buf_bytes(size_code_i);
    dlc_clip    = (int'(dlc_i) > DATA_MAX) ? DATA_MAX : int'(dlc_i);
    frame_bytes = 1 + dlc_clip;
    overflow_o  = frame_bytes > int'(size_b);
    nbytes_o    = overflow_o ? CNT_W'(size_b) : CNT_W'(frame_bytes);
  end

  // Low base bits covered by the buffer span must all be clear.
  assign aligned_o = ((base_i[8:0] & (size_b - 9'd1)) == 9'd0);
  assign onchip_o  = (base_i[15:9] == ram_page_i);
endmodule

// File: rtl/rxdma_word_sel.sv
module rxdma_word_sel #(
  parameter int IMG_BYTES = 9,
  parameter int WIDX_W    = 3,
  parameter int CNT_W     = 4
) (
  input  logic [8*IMG_BYTES-1:0] img_i,
  input  logic [WIDX_W-1:0]      widx_i,
  input  logic [CNT_W-1:0]       nbytes_i,
  output logic [15:0]            wdata_o,
  output logic [1:0]             be_o
);
  localparam int NWORDS    = (IMG_BYTES + 1) / 2;
  localparam int PAD_BYTES = 2 * NWORDS;

  logic [8*PAD_BYTES-1:0] img_pad;
  logic [15:0]            words [NWORDS];
  logic [15:0]            sel;
  logic                   hi_valid;

  generate
    if (PAD_BYTES > IMG_BYTES) begin : g_pad
      assign img_pad = {{(8*(PAD_BYTES-IMG_BYTES)){1'b0}}, img_i};
    end else begin : g_nopad
      assign img_pad = img_i;
    end
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
      assign words[gi] = img_pad[16*gi +: 16];
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (widx_i == WIDX_W'(k)) sel = words[k];
    end
    hi_valid = (2 * int'(widx_i) + 1) < int'(nbytes_i);
    be_o     = {hi_valid, 1'b1};
    wdata_o  = {hi_valid ? sel[15:8] : 8'h00, sel[7:0]};
  end
endmodule

// File: rtl/rxdma_id_merge.sv
module rxdma_id_merge
  import can_rxdma_pkg::*;
(
  input  logic [ID_W-1:0] rx_id_i,
  input  logic [ID_W-1:0] stored_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic            ext_i,
  output logic [ID_W-1:0] merged_o
);
  localparam logic [ID_W-1:0] STD_SPAN = ID_W'((1 << STD_ID_W) - 1);

  logic [ID_W-1:0] upd;

  always_comb begin
    upd      = mask_i & (ext_i ? {ID_W{1'b1}} : STD_SPAN);
    merged_o = (stored_i & ~upd) | (rx_id_i & upd);
  end
endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
  import can_rxdma_pkg::*;
#(
  parameter int WIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              aligned_i,
  input  logic              gnt_i,
  input  logic [WIDX_W-1:0] last_idx_i,
  output logic              load_o,
  output logic              req_o,
  output logic              done_o,
  output logic              cfg_err_o,
  output logic [WIDX_W-1:0] widx_o
);
  rxdma_state_e      state_q, state_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic              err_q, err_d;
  logic              widx_en;

  always_comb begin
    state_d = state_q;
    widx_d  = widx_q;
    widx_en = 1'b0;
    err_d   = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (aligned_i) begin
            load_o  = 1'b1;
            widx_en = 1'b1;
            widx_d  = '0;
            state_d = ST_REQ;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_REQ: begin
        if (gnt_i) begin
          if (widx_q == last_idx_i) begin
            state_d = ST_DONE;
          end else begin
            widx_en = 1'b1;
            widx_d  = widx_q + 1'b1;
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP:  state_d = ST_REQ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (widx_en) widx_q <= widx_d;
    end
  end

  assign req_o     = (state_q == ST_REQ);
  assign done_o    = (state_q == ST_DONE);
  assign cfg_err_o = err_q;
  assign widx_o    = widx_q;
endmodule

// File: rtl/can_rx_dma_assembler.sv
module can_rx_dma_assembler
  import can_rxdma_pkg::*;
#(
  parameter  int NUM_OBJ  = 16,
  parameter  int DATA_MAX = 8,
  localparam int IDX_W    = $clog2(NUM_OBJ),
  localparam int PB_BYTES = 1 + ID_FIELD_BYTES + DATA_MAX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [IDX_W-1:0]      obj_idx_i,
  input  logic [8*PB_BYTES-1:0] prebuf_i,
  input  logic [7:0]            segment_i,
  input  logic [15:0]           obj_base_i,
  input  logic [2:0]            obj_size_i,
  input  logic                  obj_frag_i,
  input  logic [ID_W-1:0]       obj_id_i,
  input  logic [ID_W-1:0]       obj_mask_i,
  input  logic [6:0]            ram_page_i,
  input  logic                  bus_gnt_i,
  output logic                  bus_req_o,
  output logic [23:0]           bus_addr_o,
  output logic [15:0]           bus_wdata_o,
  output logic [1:0]            bus_be_o,
  output logic                  bus_onchip_o,
  output logic                  done_o,
  output logic [IDX_W-1:0]      done_idx_o,
  output logic                  overflow_o,
  output logic                  cfg_err_o,
  output logic                  id_we_o,
  output logic [ID_W-1:0]       id_wdata_o
);
  localparam int IMG_BYTES = 1 + DATA_MAX;
  localparam int NWORDS    = (IMG_BYTES + 1) / 2;
  localparam int WIDX_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int CNT_W     = $clog2(IMG_BYTES + 1);
  localparam int ID_LSB    = 8;
  localparam int DATA_LSB  = 8 * (1 + ID_FIELD_BYTES);

  logic                     rst_n_s;
  logic [7:0]               info;
  logic [8*ID_FIELD_BYTES-1:0] id_field;
  logic                     id_spare_unused;
  logic [8*IMG_BYTES-1:0]   img_live;
  logic                     aligned, onchip_live, ovf_live;
  logic [CNT_W-1:0]         nbytes_live;
  logic [ID_W-1:0]          merged_live;

  logic                     load, req, done, err;
  logic [WIDX_W-1:0]        widx, last_idx;
  logic [15:0]              wdata;
  logic [1:0]               be;

  logic [7:0]               seg_q;
  logic [15:0]              base_q;
  logic [8*IMG_BYTES-1:0]   img_q;
  logic [CNT_W-1:0]         nbytes_q;
  logic                     ovf_q, onchip_q, frag_q;
  logic [IDX_W-1:0]         idx_q;
  logic [ID_W-1:0]          merged_q;

  rxdma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Staging buffer field split.
  assign info            = prebuf_i[7:0];
  assign id_field        = prebuf_i[ID_LSB +: 8*ID_FIELD_BYTES];
  assign id_spare_unused = ^id_field[8*ID_FIELD_BYTES-1:ID_W];
  assign img_live        = {prebuf_i[8*PB_BYTES-1:DATA_LSB], info};

  rxdma_cfg_check #(
    .DATA_MAX (DATA_MAX),
    .CNT_W    (CNT_W)
  ) u_cfg (
    .base_i      (obj_base_i),
    .size_code_i (obj_size_i),
    .ram_page_i  (ram_page_i),
    .dlc_i       (info[3:0]),
    .aligned_o   (aligned),
    .onchip_o    (onchip_live),
    .overflow_o  (ovf_live),
    .nbytes_o    (nbytes_live)
  );

  rxdma_id_merge u_idm (
    .rx_id_i  (id_field[ID_W-1:0]),
    .stored_i (obj_id_i),
    .mask_i   (obj_mask_i),
    .ext_i    (info[7]),
    .merged_o (merged_live)
  );

  rxdma_seq #(
    .WIDX_W (WIDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .aligned_i  (aligned),
    .gnt_i      (bus_gnt_i),
    .last_idx_i (last_idx),
    .load_o     (load),
    .req_o      (req),
    .done_o     (done),
    .cfg_err_o  (err),
    .widx_o     (widx)
  );

  // Transfer context, captured once per accepted start.
  always_ff @(posedge clk) begin
    if (load) begin
      seg_q    <= segment_i;
      base_q   <= obj_base_i;
      img_q    <= img_live;
      nbytes_q <= nbytes_live;
      ovf_q    <= ovf_live;
      onchip_q <= onchip_live;
      frag_q   <= obj_frag_i;
      idx_q    <= obj_idx_i;
      merged_q <= merged_live;
    end
  end

  assign last_idx = WIDX_W'((nbytes_q - CNT_W'(1)) >> 1);

  rxdma_word_sel #(
    .IMG_BYTES (IMG_BYTES),
    .WIDX_W    (WIDX_W),
    .CNT_W     (CNT_W)
  ) u_wsel (
    .img_i    (img_q),
    .widx_i   (widx),
    .nbytes_i (nbytes_q),
    .wdata_o  (wdata),
    .be_o     (be)
  );

  always_comb begin
    bus_req_o    = req;
    bus_addr_o   = req ? {seg_q, base_q + 16'({widx, 1'b0})} : 24'd0;
    bus_wdata_o  = req ? wdata : 16'd0;
    bus_be_o     = req ? be : 2'b00;
    bus_onchip_o = req & onchip_q;
    done_o       = done;
    done_idx_o   = done ? idx_q : '0;
    overflow_o   = done & ovf_q;
    cfg_err_o    = err;
    id_we_o      = done & ~frag_q;
    id_wdata_o   = (done & ~frag_q) ? merged_q : '0;
  end
endmodule

// File: rtl/can_rxdma_chk.sv
module can_rxdma_chk
  import can_rxdma_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_req_o,
  input logic            bus_gnt_i,
  input logic [23:0]     bus_addr_o,
  input logic [15:0]     bus_wdata_o,
  input logic [1:0]      bus_be_o,
  input logic            bus_onchip_o,
  input logic [6:0]      ram_page_i,
  input logic            done_o,
  input logic            cfg_err_o,
  input logic            id_we_o,
  input logic [ID_W-1:0] id_wdata_o,
  input logic [ID_W-1:0] obj_id_i,
  input logic [ID_W-1:0] obj_mask_i
);
  AST_REQ_DROP_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_gnt_i) |=> !bus_req_o);  // R5
  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o)
      && $stable(bus_wdata_o) && $stable(bus_be_o)));  // R5
  AST_LEGAL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> ((bus_be_o == 2'b11 || bus_be_o == 2'b01) && !bus_addr_o[0]));  // R3
  AST_ODD_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_be_o == 2'b01) |-> (bus_wdata_o[15:8] == 8'h00));  // R3
  AST_ONCHIP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_onchip_o == (bus_addr_o[15:9] == ram_page_i)));  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!bus_req_o && !done_o));  // R4
  AST_ID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    id_we_o |-> done_o);  // R9
  AST_ID_CARE_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    id_we_o |-> (((id_wdata_o ^ obj_id_i) & ~obj_mask_i) == '0));  // R9
endmodule

bind can_rx_dma_assembler can_rxdma_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req_o    (bus_req_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_be_o     (bus_be_o),
  .bus_onchip_o (bus_onchip_o),
  .ram_page_i   (ram_page_i),
  .done_o       (done_o),
  .cfg_err_o    (cfg_err_o),
  .id_we_o      (id_we_o),
  .id_wdata_o   (id_wdata_o),
  .obj_id_i     (obj_id_i),
  .obj_mask_i   (obj_mask_i)
);

// File: tb/test_can_rx_dma_assembler.sv
module test_can_rx_dma_assembler;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [3:0]   obj_idx;
  logic [103:0] prebuf;
  logic [7:0]   segment;
  logic [15:0]  obj_base;
  logic [2:0]   obj_size;
  logic         obj_frag;
  logic [28:0]  obj_id;
  logic [28:0]  obj_mask;
  logic [6:0]   ram_page;
  logic         gnt;
  logic         bus_req;
  logic [23:0]  bus_addr;
  logic [15:0]  bus_wdata;
  logic [1:0]   bus_be;
  logic         bus_onchip;
  logic         done;
  logic [3:0]   done_idx;
  logic         overflow;
  logic         cfg_err;
  logic         id_we;
  logic [28:0]  id_wdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  can_rx_dma_assembler i_can_rx_dma_assembler (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .obj_idx_i    (obj_idx),
    .prebuf_i     (prebuf),
    .segment_i    (segment),
    .obj_base_i   (obj_base),
    .obj_size_i   (obj_size),
    .obj_frag_i   (obj_frag),
    .obj_id_i     (obj_id),
    .obj_mask_i   (obj_mask),
    .ram_page_i   (ram_page),
    .bus_gnt_i    (gnt),
    .bus_req_o    (bus_req),
    .bus_addr_o   (bus_addr),
    .bus_wdata_o  (bus_wdata),
    .bus_be_o     (bus_be),
    .bus_onchip_o (bus_onchip),
    .done_o       (done),
    .done_idx_o   (done_idx),
    .overflow_o   (overflow),
    .cfg_err_o    (cfg_err),
    .id_we_o      (id_we),
    .id_wdata_o   (id_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [3:0] idx, input logic [7:0] seg, input logic [15:0] base,
                           input logic [2:0] code, input logic [7:0] info, input logic [28:0] rxid,
                           input logic [7:0] seed, input logic frag, input logic [28:0] sid,
                           input logic [28:0] msk, input logic [6:0] page, input bit restart);
    logic [7:0]  img [9];
    logic [15:0] edata;
    logic [1:0]  ebe;
    logic [28:0] upd, eid;
    int dlc, fb, sz, nw, nwr, k, wt;
    bit got_done;
    img[0] = info;
    for (int j = 1; j <= 8; j++) img[j] = seed + 8'(j * 37);
    dlc = (info[3:0] > 4'd8) ? 8 : int'(info[3:0]);
    fb  = 1 + dlc;
    sz  = 2 << code;
    nw  = (fb > sz) ? sz : fb;
    nwr = (nw + 1) / 2;
    upd = msk & (info[7] ? 29'h1FFF_FFFF : 29'h0000_07FF);
    eid = (sid & ~upd) | (rxid & upd);
    @(negedge clk);
    prebuf[7:0]  = info;
    prebuf[39:8] = {3'b101, rxid};
    for (int j = 1; j <= 8; j++) prebuf[40 + 8*(j-1) +: 8] = img[j];
    obj_idx = idx; segment = seg; obj_base = base; obj_size = code;
    obj_frag = frag; obj_id = sid; obj_mask = msk; ram_page = page;
    start = 1'b1;
    k = 0; wt = 0; got_done = 0;
    for (int c = 0; c < 80 && !got_done; c++) begin
      @(negedge clk);
      start   = restart && (c == 2);
      obj_idx = (restart && c == 2) ? (idx ^ 4'h3) : idx;
      if (done) begin
        got_done = 1;
        gnt = 1'b0;
        chk("R7 done index", 32'(done_idx), 32'(idx));
        chk("R6 overflow flag", 32'(overflow), 32'(fb > sz));
        chk("R9 id write strobe", 32'(id_we), 32'(!frag));
        if (!frag) chk("R9/R12 merged identifier", 32'(id_wdata), 32'(eid));
        chk("R5 no request at done", 32'(bus_req), 32'd0);
      end else if (bus_req) begin
        if (wt > 0) begin
          wt--;
          gnt = 1'b0;
        end else begin
          ebe   = (2*k + 1 < nw) ? 2'b11 : 2'b01;
          edata = {8'h00, (2*k < 9) ? img[2*k] : 8'h00};
          if (ebe == 2'b11 && 2*k + 1 < 9) edata[15:8] = img[2*k + 1];
          chk("R1 write address", 32'(bus_addr), 32'({seg, base + 16'(2*k)}));
          chk("R3 byte strobes", 32'(bus_be), 32'(ebe));
          chk("R3 write data", 32'(bus_wdata), 32'(edata));
          chk("R8 on-chip flag", 32'(bus_onchip), 32'(base[15:9] == page));
          k++;
          wt  = k % 3;
          gnt = 1'b1;
        end
      end else begin
        gnt = 1'b0;
      end
    end
    gnt   = 1'b0;
    start = 1'b0;
    chk("R7 done seen", 32'(got_done), 32'd1);
    chk("R2/R11 granted word count", 32'(k), 32'(nwr));
    @(negedge clk);
    chk("R7 done single cycle", 32'(done), 32'd0);
    chk("R10 no follow-on request", 32'(bus_req), 32'd0);
    @(negedge clk);
    chk("R10 still idle", 32'(bus_req), 32'd0);
  endtask

  task automatic run_misaligned(input logic [2:0] code, input logic [15:0] base);
    int errs, reqs, dones;
    @(negedge clk);
    obj_base = base; obj_size = code; prebuf[7:0] = 8'h08;
    start = 1'b1;
    errs = 0; reqs = 0; dones = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      start = 1'b0;
      errs += int'(cfg_err);
      reqs += int'(bus_req);
      dones += int'(done);
    end
    chk("R4 error pulse count", 32'(errs), 32'd1);
    chk("R4 no request", 32'(reqs), 32'd0);
    chk("R4 no done", 32'(dones), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; gnt = 1'b0; obj_idx = '0; prebuf = '0;
    segment = '0; obj_base = '0; obj_size = '0; obj_frag = 1'b0;
    obj_id = '0; obj_mask = '0; ram_page = '0;
    repeat (3) @(negedge clk);
    chk("R5 reset request low", 32'(bus_req), 32'd0);
    chk("R7 reset done low", 32'(done), 32'd0);
    chk("R4 reset error low", 32'(cfg_err), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int code = 0; code < 8; code++) begin
      for (int dlc = 0; dlc < 16; dlc++) begin
        logic [15:0] base;
        base = 16'h3000 + 16'((2 << code) * 3);
        run_frame(4'(dlc), 8'h40 + 8'(code), base, 3'(code),
                  {1'(code), 3'(code), 4'(dlc)},
                  29'h0ABC_1234 ^ 29'(dlc * 32'h1357),
                  8'(dlc * 11 + code), 1'(dlc), 29'h1555_5555 ^ 29'(code),
                  29'(32'h00F0_F0F3 << code),
                  dlc[1] ? base[15:9] : ~base[15:9], dlc == 5);
      end
    end

    for (int code = 0; code < 8; code++) begin
      int sz;
      sz = 2 << code;
      run_misaligned(3'(code), 16'h3000 + 16'(sz * 3) + 16'((code == 0) ? 1 : sz / 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule